// File: doc/BRIEF.md
# Oversampled Serial Receive Channel with Error-Tagged Queue

This block is the receive half of an asynchronous serial port. An external rate generator supplies a sample-tick enable at 16 or 8 times the bit rate, and the block samples the receive line on each tick. It confirms a start bit halfway through the bit and drops glitches. It then takes one sample at the centre of every data, parity and stop bit. Characters of 5 to 8 bits are assembled, checked for parity, framing and break, and written into a queue. Each queue entry holds the character and its three error tags side by side.

The host sees the entry at the head of the queue through a holding-data output and the matching tag bits. Pulsing the read strobe advances the queue, and the tags then follow the new head character. Two interrupt requests are provided. A data-ready request fires on any stored character or at a programmable fill threshold. An idle-timeout request fires when data has been waiting for longer than a span derived from the word length. Register decoding, transmit logic and rate generation sit outside the block.

Top module: `uart_rx_chan`

## Requirements
- R1: With `os8_mode`=0 a bit lasts 16 sample ticks; with `os8_mode`=1 it lasts 8. Frames sent at either rate are received without error.
- R2: A low pulse on the line that has gone high again by the half-bit sample point stores nothing, and the receiver waits for the next falling edge.
- R3: `word_len` selects 5, 6, 7 or 8 data bits (codes 0 to 3). Data arrives least significant bit first, and the unused upper bits of `hold_data` read as 0.
- R4: When `parity_en`=1 one parity bit follows the data. It makes the count of ones even (`parity_odd`=0) or odd (`parity_odd`=1). A mismatch sets tag bit 0 (`err_tags[0]`).
- R5: A stop bit sampled as 0 sets tag bit 1 (framing). If the data bits, the parity bit (when enabled) and the stop bit are all 0, tag bit 2 (break) is also set.
- R6: The queue holds up to 64 entries in arrival order. `err_tags` always belongs to the head character and changes to the next entry's tags in the cycle after a read. `data_avail` and `fill_level` report the occupancy.
- R7: A character that completes while the queue is full is discarded, the stored entries are kept, and `overrun` is set. `overrun` clears on the next read strobe.
- R8: With `fifo_en`=0 the queue holds one entry. A second unread character is an overrun.
- R9: `irq_data` is `irq_en` AND a non-empty queue AND (`fifo_en`=0 OR `fill_level` >= `trig_level`).
- R10: While the queue is not empty, `irq_timeout` (gated by `irq_en`) rises once (4*(5+`word_len`)+12) bit times of ticks pass with no new character and no read. A character or a read restarts the span, and an empty queue clears it.
- R11: After reset the queue is empty, and `overrun`, `irq_data` and `irq_timeout` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | Oversample enable, 16x or 8x the bit rate |
| rx_line | input | 1 | Serial receive line, idles high |
| os8_mode | input | 1 | 1 selects 8x oversampling, 0 selects 16x |
| word_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Parity bit present |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| fifo_en | input | 1 | 1 = 64-entry queue, 0 = single entry |
| trig_level | input | 7 | Fill threshold for data-ready |
| irq_en | input | 1 | Enables both interrupt requests |
| rd_strobe | input | 1 | Host read of the head entry, one cycle |
| hold_data | output | 8 | Head character |
| err_tags | output | 3 | Head tags: [0] parity, [1] framing, [2] break |
| data_avail | output | 1 | Queue not empty |
| fill_level | output | 7 | Number of stored entries |
| overrun | output | 1 | A character was dropped on a full queue |
| irq_data | output | 1 | Data-ready request |
| irq_timeout | output | 1 | Idle-timeout request |

## Verification
Clean frames are sent at both oversampling rates and with every word length. These patterns separate a wrong bit period and wrong bit ordering from wrong masking of the upper bits. Frames with a flipped parity bit, a zero stop bit and an all-zero line each produce a distinct tag pattern. Queues holding differently tagged entries show whether the tags stay with their own character through each read. Filling to the threshold, to 64 entries plus one, and to two entries in single-entry mode covers the interrupt threshold, the drop-on-full rule and the one-entry buffer. Idle waits, with and without an intervening read, show whether the timeout span is restarted correctly.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W = 8;
  localparam int TAG_W  = 3;
  localparam int ENT_W  = DATA_W + TAG_W;
  // idle span in bit times = 4 * (word bits) + TO_EXTRA
  localparam int TO_EXTRA = 12;
  localparam int TO_MAX_TICKS = (4 * DATA_W + TO_EXTRA) * 16;
  localparam int TO_W = $clog2(TO_MAX_TICKS + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_tags_t;
endpackage

// File: rtl/rx_deser.sv
module rx_deser
  import rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_tick,
  input  logic              rx_line,
  input  logic              os8_mode,
  input  logic [1:0]        word_len,
  input  logic              parity_en,
  input  logic              parity_odd,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output rx_tags_t          out_tags
);
  rx_state_e         state_q, state_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [2:0]        bit_q, bit_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              pbit_q, pbit_d;
  logic              meta_q, rx_s, prev_q, prev_d;
  logic              push_d;
  rx_tags_t          tags_d;
  logic [3:0]        half_m1, full_m1;
  logic [2:0]        last_bit;

  assign half_m1  = os8_mode ? 4'd3 : 4'd7;
  assign full_m1  = os8_mode ? 4'd7 : 4'd15;
  assign last_bit = {1'b0, word_len} + 3'd4;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    data_d  = data_q;
    pbit_d  = pbit_q;
    push_d  = 1'b0;
    tags_d  = '0;
    prev_d  = sample_tick ? rx_s : prev_q;
    if (sample_tick) begin
      unique case (state_q)
        ST_IDLE: begin
          if (prev_q && !rx_s) begin
            state_d = ST_START;
            cnt_d   = '0;
          end
        end
        ST_START: begin
          if (cnt_q == half_m1) begin
            cnt_d  = '0;
            bit_d  = '0;
            data_d = '0;
            pbit_d = 1'b0;
            state_d = rx_s ? ST_IDLE : ST_DATA;
          end else begin
            cnt_d = cnt_q + 4'd1;
          end
        end
        ST_DATA: begin
          if (cnt_q == full_m1) begin
            cnt_d = '0;
            data_d[bit_q] = rx_s;
            if (bit_q == last_bit) state_d = parity_en ? ST_PAR : ST_STOP;
            else                   bit_d   = bit_q + 3'd1;
          end else begin
            cnt_d = cnt_q + 4'd1;
          end
        end
        ST_PAR: begin
          if (cnt_q == full_m1) begin
            cnt_d   = '0;
            pbit_d  = rx_s;
            state_d = ST_STOP;
          end else begin
            cnt_d = cnt_q + 4'd1;
          end
        end
        ST_STOP: begin
          if (cnt_q == full_m1) begin
            push_d     = 1'b1;
            state_d    = ST_IDLE;
            tags_d.par = parity_en && ((^data_q ^ pbit_q) != parity_odd);
            tags_d.frm = !rx_s;
            tags_d.brk = !rx_s && (data_q == '0) && !(parity_en && pbit_q);
          end else begin
            cnt_d = cnt_q + 4'd1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q    <= 1'b1;
      rx_s      <= 1'b1;
      prev_q    <= 1'b1;
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      bit_q     <= '0;
      data_q    <= '0;
      pbit_q    <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_tags  <= '0;
    end else begin
      meta_q    <= rx_line;
      rx_s      <= meta_q;
      prev_q    <= prev_d;
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      bit_q     <= bit_d;
      data_q    <= data_d;
      pbit_q    <= pbit_d;
      out_valid <= push_d;
      if (push_d) begin
        out_data <= data_q;
        out_tags <= tags_d;
      end
    end
  end

  // R2: a start bit found high at the half-bit point returns to idle
  p_false_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && sample_tick && cnt_q == half_m1 && rx_s)
    |=> state_q == ST_IDLE);
  // R5: one character per frame; no back-to-back completions
  p_single_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R5: break always comes with a framing error
  p_brk_has_frm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_tags.brk) |-> out_tags.frm);
endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 11,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          single_mode,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          overrun
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovr_q, ovr_d;
  logic          cap_hit, do_wr, do_rd;

  assign cap_hit = single_mode ? (cnt_q != '0) : (cnt_q == CW'(DEPTH));
  assign do_wr   = wr_en && !cap_hit;
  assign do_rd   = rd_en && (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (do_wr && !do_rd)      cnt_d = cnt_q + CW'(1);
    else if (do_rd && !do_wr) cnt_d = cnt_q - CW'(1);
    ovr_d = ovr_q;
    if (wr_en && cap_hit) ovr_d = 1'b1;
    else if (rd_en)       ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      if (do_wr) wp_q <= wp_q + AW'(1);
      if (do_rd) rp_q <= rp_q + AW'(1);
      cnt_q <= cnt_d;
      ovr_q <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem_q[wp_q] <= wr_data;
  end

  assign head    = mem_q[rp_q];
  assign count   = cnt_q;
  assign overrun = ovr_q;

  // R6: occupancy never exceeds the depth
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R7: a write into a full queue leaves the level and raises overrun
  p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cap_hit && !rd_en) |=> (cnt_q == $past(cnt_q)) && ovr_q);
  // R6: a lone read lowers the level by one
  p_read_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CW'(1));
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_tick,
  input  logic       os8_mode,
  input  logic [1:0] word_len,
  input  logic       restart,
  input  logic       empty,
  output logic       expired
);
  logic [TO_W-1:0] cnt_q, cnt_d, bits, limit;
  logic            flag_q, flag_d;

  assign bits  = TO_W'(4 * 5 + TO_EXTRA) + (TO_W'(word_len) << 2);
  assign limit = os8_mode ? (bits << 3) : (bits << 4);

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (empty || restart) begin
      cnt_d  = '0;
      flag_d = 1'b0;
    end else if (sample_tick && !flag_q) begin
      if (cnt_q == limit - TO_W'(1)) flag_d = 1'b1;
      else                           cnt_d  = cnt_q + TO_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign expired = flag_q;

  // R10: expiry only while data waits
  p_to_nonempty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |-> !empty);
  // R10: a new character or read restarts the span
  p_to_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !flag_q);
endmodule

// File: rtl/uart_rx_chan.sv
module uart_rx_chan
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_tick,
  input  logic              rx_line,
  input  logic              os8_mode,
  input  logic [1:0]        word_len,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              fifo_en,
  input  logic [CW-1:0]     trig_level,
  input  logic              irq_en,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] hold_data,
  output logic [TAG_W-1:0]  err_tags,
  output logic              data_avail,
  output logic [CW-1:0]     fill_level,
  output logic              overrun,
  output logic              irq_data,
  output logic              irq_timeout
);
  logic              chr_valid;
  logic [DATA_W-1:0] chr_data;
  rx_tags_t          chr_tags;
  logic [ENT_W-1:0]  head;
  logic [CW-1:0]     count;
  logic              empty, to_exp;

  rx_deser u_deser (
    .clk, .rst_n, .sample_tick, .rx_line, .os8_mode, .word_len,
    .parity_en, .parity_odd,
    .out_valid(chr_valid), .out_data(chr_data), .out_tags(chr_tags)
  );

  rx_tag_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_fifo (
    .clk, .rst_n,
    .single_mode(!fifo_en),
    .wr_en(chr_valid),
    .wr_data({chr_tags, chr_data}),
    .rd_en(rd_strobe),
    .head(head), .count(count), .overrun(overrun)
  );

  assign empty = (count == '0);

  rx_idle_timer u_timer (
    .clk, .rst_n, .sample_tick, .os8_mode, .word_len,
    .restart(chr_valid || (rd_strobe && !empty)),
    .empty(empty),
    .expired(to_exp)
  );

  assign hold_data   = head[DATA_W-1:0];
  assign err_tags    = empty ? '0 : head[ENT_W-1:DATA_W];
  assign data_avail  = !empty;
  assign fill_level  = count;
  assign irq_data    = irq_en && !empty && (!fifo_en || count >= trig_level);
  assign irq_timeout = irq_en && to_exp;

  // R9: data-ready never raised with interrupts disabled or queue empty
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_data |-> (irq_en && data_avail));
endmodule

// File: tb/uart_rx_chan_bench.sv
module uart_rx_chan_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, rx_line, os8_mode, parity_en, parity_odd, fifo_en, irq_en, rd_strobe;
  logic [1:0] word_len;
  logic [6:0] trig_level, fill_level;
  logic [7:0] hold_data;
  logic [2:0] err_tags;
  logic data_avail, overrun, irq_data, irq_timeout;

  uart_rx_chan u_uart_rx_chan (
    .clk, .rst_n, .sample_tick(1'b1), .rx_line, .os8_mode, .word_len,
    .parity_en, .parity_odd, .fifo_en, .trig_level, .irq_en, .rd_strobe,
    .hold_data, .err_tags, .data_avail, .fill_level, .overrun,
    .irq_data, .irq_timeout
  );

  int total = 0, bad = 0;
  logic [10:0] exp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // driver: sends one frame, optionally queues the expected entry
  task automatic send(input logic [7:0] d, input bit stop_v, input bit par_flip, input bit store);
    int nb = 5 + int'(word_len);
    int bt = os8_mode ? 8 : 16;
    logic [7:0] dm = d & 8'((1 << nb) - 1);
    logic pbit = (^dm) ^ parity_odd ^ par_flip;
    logic [2:0] tg;
    tg[0] = parity_en & par_flip;
    tg[1] = !stop_v;
    tg[2] = !stop_v && dm == 8'd0 && !(parity_en && pbit);
    if (store) exp_q.push_back({tg, dm});
    rx_line = 1'b0;
    repeat (bt) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rx_line = d[i];
      repeat (bt) @(negedge clk);
    end
    if (parity_en) begin
      rx_line = pbit;
      repeat (bt) @(negedge clk);
    end
    rx_line = stop_v;
    repeat (bt) @(negedge clk);
    rx_line = 1'b1;
    repeat (2 * bt) @(negedge clk);
  endtask

  // monitor: compares each head entry with the scoreboard, then reads it
  task automatic drain(input string req);
    while (data_avail) begin
      logic [10:0] e;
      if (exp_q.size() == 0) begin
        check(0, req, int'(hold_data), -1);
      end else begin
        e = exp_q.pop_front();
        check(hold_data == e[7:0], req, int'(hold_data), int'(e[7:0]));
        check(err_tags == e[10:8], req, int'(err_tags), int'(e[10:8]));
      end
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      @(negedge clk);
    end
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_line = 1'b1; os8_mode = 1'b0; word_len = 2'd3;
    parity_en = 1'b0; parity_odd = 1'b0; fifo_en = 1'b1; irq_en = 1'b1;
    rd_strobe = 1'b0; trig_level = 7'd1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    check(!data_avail && fill_level == 0, "R11", int'(fill_level), 0);
    check(!overrun && !irq_data && !irq_timeout, "R11", int'({overrun, irq_data, irq_timeout}), 0);

    // R1 16x then 8x
    send(8'h55, 1, 0, 1); send(8'hA3, 1, 0, 1); send(8'hFF, 1, 0, 1);
    drain("R1_16x");
    os8_mode = 1'b1;
    send(8'h3C, 1, 0, 1); send(8'h81, 1, 0, 1);
    drain("R1_8x");
    os8_mode = 1'b0;

    // R2 glitch shorter than half a bit
    rx_line = 1'b0; repeat (4) @(negedge clk);
    rx_line = 1'b1; repeat (64) @(negedge clk);
    check(fill_level == 0, "R2", int'(fill_level), 0);
    send(8'h96, 1, 0, 1);
    drain("R2_after");

    // R3 word lengths
    word_len = 2'd0; send(8'hFF, 1, 0, 1);
    word_len = 2'd1; send(8'hC5, 1, 0, 1);
    word_len = 2'd2; send(8'hAA, 1, 0, 1);
    drain("R3");
    word_len = 2'd3;

    // R4 parity, even and odd, good and bad
    parity_en = 1'b1;
    parity_odd = 1'b0; send(8'h37, 1, 0, 1); send(8'h37, 1, 1, 1);
    parity_odd = 1'b1; send(8'h0F, 1, 0, 1); send(8'h0E, 1, 1, 1);
    drain("R4");
    parity_en = 1'b0;

    // R5 framing and break; R6 tags follow the head
    send(8'h5A, 0, 0, 1); send(8'h00, 0, 0, 1); send(8'h12, 1, 0, 1);
    drain("R5_R6");

    // R9 threshold and gating
    trig_level = 7'd4;
    send(8'h01, 1, 0, 1); send(8'h02, 1, 0, 1); send(8'h03, 1, 0, 1);
    check(!irq_data && fill_level == 3, "R9", int'(irq_data), 0);
    send(8'h04, 1, 0, 1);
    check(irq_data == 1'b1, "R9", int'(irq_data), 1);
    irq_en = 1'b0; @(negedge clk);
    check(irq_data == 1'b0, "R9_gate", int'(irq_data), 0);
    irq_en = 1'b1;
    drain("R9");
    trig_level = 7'd1;

    // R7 full queue drop and overrun clear
    for (int k = 0; k < 64; k++) send(8'(k * 7 + 3), 1, 0, 1);
    send(8'hEE, 1, 0, 0);
    check(fill_level == 64, "R7", int'(fill_level), 64);
    check(overrun == 1'b1, "R7", int'(overrun), 1);
    drain("R7");
    check(overrun == 1'b0, "R7_clear", int'(overrun), 0);

    // R8 single entry
    fifo_en = 1'b0;
    send(8'h61, 1, 0, 1); send(8'h62, 1, 0, 0);
    check(fill_level == 1 && overrun, "R8", int'(fill_level), 1);
    check(irq_data == 1'b1, "R8_R9", int'(irq_data), 1);
    drain("R8");
    fifo_en = 1'b1;

    // R10 timeout: 44 bit times * 16 = 704 ticks after the last push
    send(8'h77, 1, 0, 1);
    repeat (600) @(negedge clk);
    check(irq_timeout == 1'b0, "R10_early", int'(irq_timeout), 0);
    repeat (100) @(negedge clk);
    check(irq_timeout == 1'b1, "R10", int'(irq_timeout), 1);
    drain("R10");
    check(irq_timeout == 1'b0, "R10_empty", int'(irq_timeout), 0);

    // R10 read restarts the span
    send(8'h21, 1, 0, 1); send(8'h22, 1, 0, 1);
    repeat (400) @(negedge clk);
    check(hold_data == 8'h21, "R10_rd", int'(hold_data), 33);
    void'(exp_q.pop_front());
    rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
    repeat (400) @(negedge clk);
    check(irq_timeout == 1'b0, "R10_restart", int'(irq_timeout), 0);
    repeat (400) @(negedge clk);
    check(irq_timeout == 1'b1, "R10_restart", int'(irq_timeout), 1);
    drain("R10_tail");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule